// File: doc/BRIEF.md
# Stochastic Leaky Integrate-and-Fire Neuron

This block is one digital spiking neuron. A 16-bit linear-feedback shift register runs as the neuron's noise source. On each enabled cycle, its top three bits select one of eight programmable activation probabilities, and its low byte serves as a uniform random number that is compared against the selected entry. When the comparison succeeds, the membrane receives a stochastic input event. An external spike pin also produces input events. Each accepted event adds a programmable weight to a saturating 16-bit membrane. On cycles with no event, the membrane decays toward zero by a programmable amount.

When an event lifts the upper byte of the membrane to the programmed threshold, the neuron emits a one-cycle spike and clears the membrane. It then ignores every input for a programmable number of cycles. A saturating counter records how many spikes have occurred. All settings are held in a small register file that a bus bridge writes through a single write strobe. Surrounding logic uses the neuron as a probabilistic firing element: the activation table shapes the firing-rate curve, and the threshold, weight and leak registers tune the integration.

Top module: `slif_neuron`

## Requirements
- R1: After reset, `membrane` is 0, `spike_out` is 0, `rng_state` is 16'hACE1, and the spike counter reads 0. The registers reset to these values: threshold 8'hFF, weight 0, leak 0, refractory length 0, enable 0, polynomial 16'hB400, and every activation entry 0.
- R2: The generator shifts left once per cycle while the enable bit (bit 0 at address 0) is set. The bit shifted in is the XOR of `state & poly`. With the default polynomial 16'hB400, the sequence returns to its starting state after exactly 65535 steps and not before.
- R3: On an enabled cycle, a stochastic event occurs when `rng_state[7:0]` is below the activation entry indexed by `rng_state[15:13]`. Entry k is at address 16+k. The event is judged on the state held before that cycle's shift.
- R4: An accepted event adds `weight << 8` to the membrane. A sum above 16'hFFFF is clamped to 16'hFFFF and does not wrap.
- R5: On every cycle without an accepted event, the membrane loses the leak amount, which is counted in units of the low byte. If the membrane would go below zero, it is set to 0.
- R6: On a cycle with an accepted event, if the upper byte of the new membrane value is greater than or equal to the threshold, `spike_out` is 1 for the following cycle and the membrane becomes 0. Otherwise `spike_out` is 0.
- R7: After a spike, input events from both the spike pin and the generator are ignored for exactly the programmed refractory length, counted in cycles.
- R8: An 8-bit spike counter, read at address 9, increments on each spike and holds at 255.
- R9: A write takes effect at the clock edge on which `cfg_we` is sampled high. The register addresses are: 0 enable, 1 threshold, 2 weight, 3 leak, 4 refractory length, 5 and 6 polynomial (low and high byte), 7 and 8 seed (low and high byte). Writes to address 9 are ignored. `cfg_rdata` returns the addressed register combinationally.
- R10: Writing the seed high byte loads the generator with {high, stored low}. If a loaded value or a next state would be zero, 16'hACE1 is loaded in its place, so the state is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| in_spike | input | 1 | External input spike |
| spike_out | output | 1 | Output spike pulse |
| membrane | output | 16 | Membrane potential |
| rng_state | output | 16 | Current generator state |

## Verification
The hardest condition to reach from the ports is the stochastic firing path with a known outcome, because each firing decision depends on a 16-bit pseudorandom state. The bench loads a known seed through the register port and programs a graded activation table. It then steps its own generator model in lockstep with the design, predicting every firing decision and the resulting membrane value. Membrane saturation is reached by choosing a weight that makes two events overflow 16 bits exactly at the maximum threshold. In that case a spike occurs only if the sum clamps rather than wraps.

// File: rtl/slif_pkg.sv
package slif_pkg;
   // register address map
   localparam int ADR_CTRL    = 0;
   localparam int ADR_THRESH  = 1;
   localparam int ADR_WEIGHT  = 2;
   localparam int ADR_LEAK    = 3;
   localparam int ADR_REFR    = 4;
   localparam int ADR_POLY_LO = 5;
   localparam int ADR_POLY_HI = 6;
   localparam int ADR_SEED_LO = 7;
   localparam int ADR_SEED_HI = 8;
   localparam int ADR_COUNT   = 9;
   localparam int ADR_TBL     = 16;
endpackage

// File: rtl/slif_regs.sv
module slif_regs
   import slif_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 5,
   parameter int RNG_W     = 16,
   parameter int TBL_DEPTH = 8,
   parameter int REFR_W    = 8,
   parameter int CNT_W     = 8,
   parameter logic [RNG_W-1:0] DEF_POLY = 16'hB400
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [DATA_W-1:0]           wdata,
   output logic [DATA_W-1:0]           rdata,
   input  logic [CNT_W-1:0]            spike_count,
   output logic                        stoch_en,
   output logic [DATA_W-1:0]           thresh,
   output logic [DATA_W-1:0]           weight,
   output logic [DATA_W-1:0]           leak,
   output logic [REFR_W-1:0]           refr_len,
   output logic [RNG_W-1:0]            poly,
   output logic                        seed_load,
   output logic [RNG_W-1:0]            seed,
   output logic [TBL_DEPTH*DATA_W-1:0] tbl_flat
);
   logic [DATA_W-1:0] seed_lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stoch_en  <= 1'b0;
         thresh    <= '1;
         weight    <= '0;
         leak      <= '0;
         refr_len  <= '0;
         poly      <= DEF_POLY;
         seed_lo_q <= '0;
      end else if (we) begin
         case (addr)
            ADDR_W'(ADR_CTRL):    stoch_en  <= wdata[0];
            ADDR_W'(ADR_THRESH):  thresh    <= wdata;
            ADDR_W'(ADR_WEIGHT):  weight    <= wdata;
            ADDR_W'(ADR_LEAK):    leak      <= wdata;
            ADDR_W'(ADR_REFR):    refr_len  <= wdata[REFR_W-1:0];
            ADDR_W'(ADR_POLY_LO): poly[DATA_W-1:0]     <= wdata;
            ADDR_W'(ADR_POLY_HI): poly[RNG_W-1:DATA_W] <= wdata;
            ADDR_W'(ADR_SEED_LO): seed_lo_q <= wdata;
            default: ;
         endcase
      end
   end

   // seed high write loads the generator at the same edge
   assign seed_load = we && (addr == ADDR_W'(ADR_SEED_HI));
   assign seed      = {wdata, seed_lo_q};

   // activation entries, one register each
   for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_entry
      logic [DATA_W-1:0] entry_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            entry_q <= '0;
         else if (we && addr == ADDR_W'(ADR_TBL + g))
            entry_q <= wdata;
      end
      assign tbl_flat[g*DATA_W +: DATA_W] = entry_q;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(ADR_CTRL):    rdata = DATA_W'(stoch_en);
         ADDR_W'(ADR_THRESH):  rdata = thresh;
         ADDR_W'(ADR_WEIGHT):  rdata = weight;
         ADDR_W'(ADR_LEAK):    rdata = leak;
         ADDR_W'(ADR_REFR):    rdata = DATA_W'(refr_len);
         ADDR_W'(ADR_POLY_LO): rdata = poly[DATA_W-1:0];
         ADDR_W'(ADR_POLY_HI): rdata = poly[RNG_W-1:DATA_W];
         ADDR_W'(ADR_SEED_LO): rdata = seed_lo_q;
         ADDR_W'(ADR_COUNT):   rdata = DATA_W'(spike_count);
         default: begin
            for (int k = 0; k < TBL_DEPTH; k++)
               if (addr == ADDR_W'(ADR_TBL + k))
                  rdata = tbl_flat[k*DATA_W +: DATA_W];
         end
      endcase
   end
endmodule

// File: rtl/slif_lfsr.sv
module slif_lfsr #(
   parameter int W = 16,
   parameter logic [W-1:0] FIX_SEED = 16'hACE1,
   parameter bit GALOIS = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic         load,
   input  logic [W-1:0] seed,
   input  logic [W-1:0] poly,
   output logic [W-1:0] state
);
   logic [W-1:0] cand;

   if (FIX_SEED == '0) begin : g_bad_fix
      $error("slif_lfsr: FIX_SEED must be nonzero");
   end

   if (GALOIS) begin : g_galois
      always_comb cand = {1'b0, state[W-1:1]} ^ (state[0] ? poly : '0);
   end else begin : g_fibonacci
      always_comb cand = {state[W-2:0], ^(state & poly)};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         state <= FIX_SEED;
      else if (load)
         state <= (seed == '0) ? FIX_SEED : seed;
      else if (adv)
         state <= (cand == '0) ? FIX_SEED : cand;
   end

   assert_never_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);
endmodule

// File: rtl/slif_membrane.sv
module slif_membrane #(
   parameter int MEM_W  = 16,
   parameter int DATA_W = 8,
   parameter int REFR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_raw,
   input  logic [DATA_W-1:0] weight,
   input  logic [DATA_W-1:0] leak,
   input  logic [DATA_W-1:0] thresh,
   input  logic [REFR_W-1:0] refr_len,
   output logic [MEM_W-1:0]  mem_q,
   output logic              spike_q
);
   localparam int SH = MEM_W - DATA_W;

   logic [REFR_W-1:0] refr_q;
   logic              refr_active, ev, fire_now;
   logic [MEM_W:0]    sum;
   logic [MEM_W-1:0]  add, sat, lk, leaked, nxt;

   assign refr_active = (refr_q != '0);
   assign ev          = ev_raw && !refr_active;
   assign add         = MEM_W'(weight) << SH;
   assign sum         = {1'b0, mem_q} + {1'b0, add};
   assign sat         = sum[MEM_W] ? '1 : sum[MEM_W-1:0];
   assign lk          = MEM_W'(leak);
   assign leaked      = (mem_q > lk) ? (mem_q - lk) : '0;
   assign nxt         = ev ? sat : leaked;
   assign fire_now    = ev && (nxt[MEM_W-1 -: DATA_W] >= thresh);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_q   <= '0;
         spike_q <= 1'b0;
         refr_q  <= '0;
      end else if (fire_now) begin
         mem_q   <= '0;
         spike_q <= 1'b1;
         refr_q  <= refr_len;
      end else begin
         mem_q   <= nxt;
         spike_q <= 1'b0;
         refr_q  <= refr_active ? refr_q - 1'b1 : '0;
      end
   end

   assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && !fire_now) |=> (mem_q >= $past(mem_q)));
   assert_leak_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ev |=> (mem_q <= $past(mem_q)));
   assert_spike_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      spike_q |-> (mem_q == '0));
   assert_refr_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      refr_active |=> (mem_q == '0 && !spike_q));
endmodule

// File: rtl/slif_counter.sv
module slif_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt_q
);
   localparam logic [W-1:0] MAX = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (inc && cnt_q != MAX)
         cnt_q <= cnt_q + 1'b1;
   end

   assert_hold_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == MAX) |=> (cnt_q == MAX));
   assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && cnt_q != MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/slif_neuron.sv
module slif_neuron #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 5,
   parameter int RNG_W     = 16,
   parameter int MEM_W     = 16,
   parameter int TBL_DEPTH = 8,
   parameter int REFR_W    = 8,
   parameter int CNT_W     = 8,
   parameter logic [RNG_W-1:0] FIX_SEED = 16'hACE1,
   parameter logic [RNG_W-1:0] DEF_POLY = 16'hB400,
   parameter bit RNG_GALOIS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              in_spike,
   output logic              spike_out,
   output logic [MEM_W-1:0]  membrane,
   output logic [RNG_W-1:0]  rng_state
);
   localparam int IDX_W = $clog2(TBL_DEPTH);

   if (RNG_W != 2*DATA_W) begin : g_bad_rng
      $error("slif_neuron: RNG_W must be twice DATA_W");
   end
   if ((1 << IDX_W) != TBL_DEPTH) begin : g_bad_depth
      $error("slif_neuron: TBL_DEPTH must be a power of two");
   end
   if (MEM_W < DATA_W || REFR_W > DATA_W || CNT_W > DATA_W) begin : g_bad_width
      $error("slif_neuron: inconsistent widths");
   end
   if (slif_pkg::ADR_TBL + TBL_DEPTH > (1 << ADDR_W)) begin : g_bad_addr
      $error("slif_neuron: table does not fit the address space");
   end

   logic                        stoch_en, seed_load;
   logic [DATA_W-1:0]           thresh, weight, leak, entry, cmp;
   logic [REFR_W-1:0]           refr_len;
   logic [RNG_W-1:0]            poly, seed;
   logic [TBL_DEPTH*DATA_W-1:0] tbl_flat;
   logic [CNT_W-1:0]            spike_count;
   logic [IDX_W-1:0]            idx;
   logic                        fire;

   slif_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RNG_W(RNG_W), .TBL_DEPTH(TBL_DEPTH),
      .REFR_W(REFR_W), .CNT_W(CNT_W), .DEF_POLY(DEF_POLY)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .spike_count(spike_count), .stoch_en(stoch_en),
      .thresh(thresh), .weight(weight), .leak(leak), .refr_len(refr_len),
      .poly(poly), .seed_load(seed_load), .seed(seed), .tbl_flat(tbl_flat)
   );

   slif_lfsr #(.W(RNG_W), .FIX_SEED(FIX_SEED), .GALOIS(RNG_GALOIS)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .adv(stoch_en), .load(seed_load),
      .seed(seed), .poly(poly), .state(rng_state)
   );

   // top bits pick the probability entry, low byte is the random draw
   assign idx   = rng_state[RNG_W-1 -: IDX_W];
   assign cmp   = rng_state[DATA_W-1:0];
   assign entry = tbl_flat[idx*DATA_W +: DATA_W];
   assign fire  = stoch_en && (cmp < entry);

   slif_membrane #(.MEM_W(MEM_W), .DATA_W(DATA_W), .REFR_W(REFR_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .ev_raw(fire || in_spike), .weight(weight),
      .leak(leak), .thresh(thresh), .refr_len(refr_len),
      .mem_q(membrane), .spike_q(spike_out)
   );

   slif_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(spike_out), .cnt_q(spike_count)
   );

   assert_idle_no_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!stoch_en && !in_spike && !seed_load) |=> $stable(rng_state));
endmodule

// File: tb/slif_neuron_tb.sv
module slif_neuron_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] FIX = 16'hACE1;
   localparam logic [15:0] POLY = 16'hB400;
   // {in_spike, expected spike, expected membrane}
   localparam int NVEC = 10;
   localparam logic [17:0] VEC [NVEC] = '{
      {1'b1, 1'b0, 16'h1000}, {1'b0, 1'b0, 16'h0FC0}, {1'b1, 1'b0, 16'h1FC0},
      {1'b1, 1'b0, 16'h2FC0}, {1'b0, 1'b0, 16'h2F80}, {1'b1, 1'b1, 16'h0000},
      {1'b1, 1'b0, 16'h0000}, {1'b1, 1'b0, 16'h0000}, {1'b1, 1'b0, 16'h1000},
      {1'b0, 1'b0, 16'h0FC0}};

   logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, in_spike = 1'b0;
   logic [4:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0, cfg_rdata;
   logic spike_out;
   logic [15:0] membrane, rng_state;
   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   slif_neuron u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_spike(in_spike),
      .spike_out(spike_out), .membrane(membrane), .rng_state(rng_state)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int a, input logic [7:0] exp);
      cfg_addr = 5'(a);
      #1;
      chk(req, 32'(cfg_rdata), 32'(exp));
   endtask

   function automatic logic [15:0] lfsr_next(input logic [15:0] s, input logic [15:0] p);
      logic [15:0] c;
      c = {s[14:0], ^(s & p)};
      return (c == 16'h0) ? FIX : c;
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] tbl [8];
      logic [15:0] s, m;
      bit early;
      repeat (3) tick();
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 membrane", 32'(membrane), 32'h0);
      chk("R1 spike", 32'(spike_out), 32'h0);
      chk("R1 rng", 32'(rng_state), 32'(FIX));
      rd_chk("R1 count", 9, 8'h00);
      rd_chk("R1 thresh", 1, 8'hFF);

      // R9 config then R4/R5/R6/R7 via vector walk
      wr(2, 8'h10); wr(1, 8'h30); wr(3, 8'h40); wr(4, 8'h02);
      rd_chk("R9 weight readback", 2, 8'h10);
      for (int i = 0; i < NVEC; i++) begin
         in_spike = VEC[i][17];
         tick();
         chk($sformatf("R6/R7 vec%0d spike", i), 32'(spike_out), 32'(VEC[i][16]));
         chk($sformatf("R4/R5/R7 vec%0d membrane", i), 32'(membrane), 32'(VEC[i][15:0]));
      end
      in_spike = 1'b0;

      // R5 leak clamp: write cycle still uses old leak 0x40
      wr(3, 8'hFF);
      chk("R5 leak old", 32'(membrane), 32'h0F80);
      tick();
      chk("R5 leak new", 32'(membrane), 32'h0E81);
      repeat (20) tick();
      chk("R5 clamp zero", 32'(membrane), 32'h0);

      // R6 threshold equality
      wr(3, 8'h00); wr(4, 8'h00); wr(1, 8'h10);
      in_spike = 1'b1; tick(); in_spike = 1'b0;
      chk("R6 equal threshold spike", 32'(spike_out), 32'h1);
      chk("R6 reset membrane", 32'(membrane), 32'h0);
      tick();
      chk("R6 single pulse", 32'(spike_out), 32'h0);

      // R4 saturation: two 0x8000 adds clamp to FFFF and reach threshold FF
      wr(1, 8'hFF); wr(2, 8'h80);
      in_spike = 1'b1; tick();
      chk("R4 first add", 32'(membrane), 32'h8000);
      chk("R4 no spike yet", 32'(spike_out), 32'h0);
      tick(); in_spike = 1'b0;
      chk("R4 saturate spike", 32'(spike_out), 32'h1);

      // R8 count and R9 read-only
      tick();
      rd_chk("R8 count three", 9, 8'd3);
      wr(9, 8'h00);
      rd_chk("R9 count write ignored", 9, 8'd3);

      // R3/R2 stochastic path against model
      for (int k = 0; k < 8; k++) begin
         tbl[k] = (k == 7) ? 8'hFF : 8'(k * 40);
         wr(16 + k, tbl[k]);
      end
      wr(2, 8'h01); wr(1, 8'hFF);
      wr(7, 8'h34); wr(8, 8'h12);
      chk("R10 seed load", 32'(rng_state), 32'h1234);
      wr(0, 8'h01);
      s = 16'h1234; m = membrane;
      for (int c = 0; c < 200; c++) begin
         if (s[7:0] < tbl[s[15:13]]) m = m + 16'h0100;
         s = lfsr_next(s, POLY);
         tick();
         chk("R3 membrane", 32'(membrane), 32'(m));
         chk("R2 rng", 32'(rng_state), 32'(s));
      end

      // R2 period
      wr(0, 8'h00);
      wr(7, 8'hE1); wr(8, 8'hAC);
      wr(0, 8'h01);
      early = 1'b0;
      for (int c = 1; c <= 65535; c++) begin
         tick();
         if (c < 65535 && rng_state == FIX) early = 1'b1;
      end
      chk("R2 period end", 32'(rng_state), 32'(FIX));
      chk("R2 no early repeat", 32'(early), 32'h0);

      // R10 zero seed
      wr(0, 8'h00);
      wr(7, 8'h00); wr(8, 8'h00);
      chk("R10 zero seed replaced", 32'(rng_state), 32'(FIX));

      // R8 counter saturation
      wr(1, 8'h00); wr(2, 8'h01); wr(4, 8'h00);
      in_spike = 1'b1;
      repeat (300) tick();
      in_spike = 1'b0;
      tick();
      rd_chk("R8 count saturated", 9, 8'd255);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule